// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches eight external pins and turns their activity into interrupt requests for a CPU. The four low-numbered lines react only to a low level: a request exists for as long as such a pin is held low. Each of the four high-numbered lines can react to a low level, a falling edge or a rising edge, chosen by a two-bit sense field. An edge event latches a flag that stays set until the CPU acknowledges that line or software writes a one to it.

Every pin passes through a two-flop synchroniser before any decision is made. Pin activity is sensed whatever the pad direction is, so software can raise an interrupt by driving one of these pins itself. A small register bus gives read and write access to a mask register, a flag register and a sense register. A line's request reaches the CPU only when its mask bit and the global enable input are both set. A combined request and the index of the lowest-numbered active line are also provided.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Lines 0 to 3 are always low-level sensitive: a line's pending state equals its synchronised pin being 0.
- R2: Line 4+k (k = 0..3) takes its sense code from sense register bits [2k+1:2k]. Code 00 selects low level, code 10 selects falling edge and code 11 selects rising edge.
- R3: A detected edge on line 4+k sets flag bit 4+k, read at bus address 1. An edge-mode line is pending while its flag is set.
- R4: A flag is cleared by ack_i on that line or by a bus write of 1 to that bit at address 1. A written 0 has no effect. An edge detected in the same cycle as a clear keeps the flag set.
- R5: A flag is held at 0 while its line's sense code is 00 or 01. Code 01 yields neither a request nor a flag.
- R6: Flag register bits 3:0 always read 0, and writes to them are ignored.
- R7: irq_o equals the pending lines ANDed with the mask register (address 0) and with gie_i.
- R8: irq_any_o is the OR of irq_o. irq_id_o is the lowest index set in irq_o, and 0 when none is set.
- R9: A level request appears two clock edges after a pin change. An edge flag sets on the third edge. A pulse held for two or more clock periods is always detected.
- R10: Address 0 holds the mask and address 2 holds the sense fields, both read/write. Address 3 reads 0. After reset all registers are 0 and no request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 8 | Per-line acknowledge from the CPU |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_o | output | 8 | Per-line gated requests |
| irq_any_o | output | 1 | Any request active |
| irq_id_o | output | 3 | Lowest active line index |

## Verification
A new edge on a high line and a clear of that same line's flag can land on the same clock edge. The clear can come from ack_i or from a bus write of one. The bench sets a flag first and then drops the pin again. It times the acknowledge so that it covers the one cycle in which the synchronised falling edge is seen. It then reads the flag register and expects the bit still set. A separate test with the acknowledge alone shows that the clear does work, so the kept bit can only come from the set taking priority.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter logic [7:0] PIN_IDLE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pin_i,
  input  logic       gie_i,
  input  logic [7:0] ack_i,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] irq_o,
  output logic       irq_any_o,
  output logic [2:0] irq_id_o
);

  logic [7:0] sync1_q, sync2_q, prev_q;
  logic [7:0] mask_q, sense_q;
  logic [3:0] flag_q, flag_d;
  logic [7:0] pend;

  wire wr_mask  = bus_we && (bus_addr == 2'd0);
  wire wr_flag  = bus_we && (bus_addr == 2'd1);
  wire wr_sense = bus_we && (bus_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= PIN_IDLE;
      sync2_q <= PIN_IDLE;
      prev_q  <= PIN_IDLE;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= bus_wdata;
      if (wr_sense) sense_q <= bus_wdata;
    end
  end

  assign pend[3:0] = ~sync2_q[3:0];

  for (genvar k = 0; k < 4; k++) begin : g_edge
    logic [1:0] mode;
    logic       fall, rise, hit, clr;
    assign mode = sense_q[2*k+1 -: 2];
    assign fall = prev_q[k+4] & ~sync2_q[k+4];
    assign rise = ~prev_q[k+4] & sync2_q[k+4];
    assign hit  = (mode == 2'b10) ? fall : (mode == 2'b11) ? rise : 1'b0;
    assign clr  = ack_i[k+4] | (wr_flag & bus_wdata[k+4]);
    assign flag_d[k] = !mode[1] ? 1'b0 : hit ? 1'b1 : clr ? 1'b0 : flag_q[k];
    assign pend[k+4] = (mode == 2'b00) ? ~sync2_q[k+4] : (mode[1] & flag_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq_o     = pend & mask_q & {8{gie_i}};
  assign irq_any_o = |irq_o;

  always_comb begin
    irq_id_o = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (irq_o[i]) irq_id_o = 3'(i);
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = mask_q;
      2'd1:    bus_rdata = {flag_q, 4'b0000};
      2'd2:    bus_rdata = sense_q;
      default: bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie_i,
  input logic [7:0] irq_o,
  input logic       irq_any_o,
  input logic [2:0] irq_id_o,
  input logic [7:0] mask_q,
  input logic [7:0] sense_q,
  input logic [3:0] flag_q,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata
);

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~mask_q) == 8'h00);

  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> irq_o == 8'h00);

  // R8
  any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o == (irq_o != 8'h00));

  // R8
  id_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o |-> (irq_o[irq_id_o] && ((irq_o & ((8'd1 << irq_id_o) - 8'd1)) == 8'h00)));

  // R6
  flag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> bus_rdata[3:0] == 4'h0);

  for (genvar k = 0; k < 4; k++) begin : g_lvl
    // R5
    flag_lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_q[2*k+1] |=> !flag_q[k]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .irq_o(irq_o),
  .irq_any_o(irq_any_o), .irq_id_o(irq_id_o), .mask_q(mask_q),
  .sense_q(sense_q), .flag_q(flag_q), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] pin_i = 8'hFF, ack_i = 8'h00, bus_wdata = 8'h00;
  logic       gie_i = 0, bus_we = 0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_rdata, irq_o;
  logic       irq_any_o;
  logic [2:0] irq_id_o;

  int checks = 0, fails = 0;
  bit done = 0;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_any_o(irq_any_o),
    .irq_id_o(irq_id_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: sense, mask, gie, pins, expected irq
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'hFF, 1'b1, 8'hFE, 8'h01},
    {8'h00, 8'hFF, 1'b1, 8'h7F, 8'h80},
    {8'h00, 8'h0F, 1'b1, 8'h00, 8'h0F},
    {8'h00, 8'hFF, 1'b0, 8'h00, 8'h00},
    {8'h55, 8'hFF, 1'b1, 8'h00, 8'h0F},
    {8'hAA, 8'hFF, 1'b1, 8'hFF, 8'h00},
    {8'h00, 8'hA4, 1'b1, 8'h00, 8'hA4},
    {8'h00, 8'hF0, 1'b1, 8'h00, 8'hF0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [2:0] low_id(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) low_id = 3'(i);
    if (v == 0) low_id = 3'd0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    tick(2);
    rst_n = 1;
    tick(1);
    // R10 reset state
    rd(2'd0, r); check("R10 mask reset", r, 8'h00);
    rd(2'd1, r); check("R10 flag reset", r, 8'h00);
    rd(2'd2, r); check("R10 sense reset", r, 8'h00);
    check("R10 irq reset", irq_o, 8'h00);

    // R1 R2 R5 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      wr(2'd2, VEC[v][32:25]);
      wr(2'd0, VEC[v][24:17]);
      gie_i = VEC[v][16];
      pin_i = VEC[v][15:8];
      tick(4);
      check($sformatf("R7 vec%0d irq", v), irq_o, VEC[v][7:0]);
      check($sformatf("R8 vec%0d any", v), {7'd0, irq_any_o}, {7'd0, VEC[v][7:0] != 0});
      check($sformatf("R8 vec%0d id", v), {5'd0, irq_id_o}, {5'd0, low_id(VEC[v][7:0])});
    end

    // R10 register read back and address 3
    rd(2'd0, r); check("R10 mask readback", r, 8'hF0);
    rd(2'd3, r); check("R10 addr3 zero", r, 8'h00);

    // R9 level latency: two edges
    pin_i = 8'hFF; wr(2'd0, 8'hFF); tick(4);
    pin_i = 8'hFD;
    @(posedge clk); @(negedge clk);
    check("R9 level after one edge", irq_o, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R9 level after two edges R1", irq_o, 8'h02);
    pin_i = 8'hFF; tick(4);

    // R2 R3 R9 falling edge on line 5, two-cycle pulse
    wr(2'd2, 8'h08);
    pin_i = 8'hDF; tick(2);
    pin_i = 8'hFF;
    rd(2'd1, r); check("R9 flag not yet after two edges", r, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(2'd1, r); check("R3 flag set line5", r, 8'h20);
    tick(4);
    check("R3 edge irq held", irq_o, 8'h20);
    check("R8 id line5", {5'd0, irq_id_o}, 8'd5);

    // R7 gie gating keeps flag
    gie_i = 0; tick(1);
    check("R7 gie low irq", irq_o, 8'h00);
    rd(2'd1, r); check("R7 flag kept under gie low", r, 8'h20);
    gie_i = 1;

    // R4 write 0 no effect, write 1 clears
    wr(2'd1, 8'h00); rd(2'd1, r); check("R4 write zero keeps", r, 8'h20);
    wr(2'd1, 8'h20); rd(2'd1, r); check("R4 write one clears", r, 8'h00);

    // R4 ack clears
    pin_i = 8'hDF; tick(4); pin_i = 8'hFF; tick(4);
    rd(2'd1, r); check("R4 flag set again", r, 8'h20);
    ack_i = 8'h20; @(negedge clk); ack_i = 8'h00;
    rd(2'd1, r); check("R4 ack clears", r, 8'h00);

    // R4 edge and ack in the same cycle: set wins
    pin_i = 8'hDF; tick(4); pin_i = 8'hFF; tick(4);
    pin_i = 8'hDF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    ack_i = 8'h20;
    @(negedge clk);
    ack_i = 8'h00;
    rd(2'd1, r); check("R4 edge wins over ack", r, 8'h20);
    pin_i = 8'hFF; tick(4);

    // R6 reserved flag bits
    pin_i = 8'hF0; wr(2'd1, 8'h0F); tick(3);
    rd(2'd1, r); check("R6 low flag bits zero", r & 8'h0F, 8'h00);
    pin_i = 8'hFF; tick(3);

    // R5 level mode clears flag
    rd(2'd1, r); check("R5 flag before mode change", r, 8'h20);
    wr(2'd2, 8'h00); @(negedge clk);
    rd(2'd1, r); check("R5 level mode clears flag", r, 8'h00);

    // R5 reserved code 01 on line 6
    wr(2'd2, 8'h10);
    pin_i = 8'hBF; tick(4); pin_i = 8'hFF; tick(4);
    rd(2'd1, r); check("R5 reserved code no flag", r, 8'h00);
    pin_i = 8'hBF; tick(4);
    check("R5 reserved code no irq", irq_o, 8'h00);
    pin_i = 8'hFF; tick(4);

    // R2 rising edge on line 7
    wr(2'd2, 8'hC0);
    pin_i = 8'h7F; tick(4);
    rd(2'd1, r); check("R2 rising mode ignores fall", r, 8'h00);
    pin_i = 8'hFF; tick(4);
    rd(2'd1, r); check("R2 rising edge flag line7", r, 8'h80);
    check("R8 id line7", {5'd0, irq_id_o}, 8'd7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule